// File: doc/BRIEF.md
# Page-Offset-Indexed, Physically-Tagged Read Cache

This block is the read side of a direct-mapped data cache whose set and word are chosen only from the untranslated page-offset bits of a virtual address. When a request is accepted, the cache captures those offset bits to address its arrays. In the same cycle it sends the virtual page number to an external translation unit. Each cache entry holds a physical page number as its tag. The hit decision compares that stored tag with the physical page number the translation unit returns. As a result, the translation lookup and the array lookup run in parallel rather than one after the other.

A request moves into a one-entry lookup stage when `reqReady` is high. The lookup stage waits there until the translation port reports a valid result. In the cycle that result is valid, the block reports hit or miss, returns the selected word on a hit, and drives the physical address. The physical address is the translated page number joined with the page offset. While the translation result is not valid, the block reports nothing and holds the request.

Lines are installed through a fill port. The fill port writes a whole block, its physical tag and its valid bit in one cycle. The set-index and word-offset widths together must fit inside the page offset, and elaboration stops when they do not.

Top module: `vipt_dcache`

## Requirements
- R1: With default parameters, an accepted request uses `reqVaddr[5:2]` as the set and `reqVaddr[1:0]` as the word. In the acceptance cycle it drives `xlatReq` high and `xlatVpn` equal to `reqVaddr[15:8]`.
- R2: In a cycle with a request in the stage, `xlatValid` high, a valid entry, and a stored tag equal to `xlatPpn`, the block raises `respHit` with `respMiss` low. In that cycle `respData` is the selected word of the entry.
- R3: In a cycle with a request in the stage and `xlatValid` high, `respMiss` rises with `respHit` low if the entry is invalid or its tag differs from `xlatPpn`. On a miss, `respData` is zero.
- R4: While a request is in the stage and `xlatValid` is low, `respHit`, `respMiss` and `reqReady` are all low, and the request is kept. A later valid translation completes that same request.
- R5: When `fillValid` is high, one clock edge writes all words of `fillLine` (word w in bits `[16w+15:16w]`), the tag `fillPpn` and the valid bit of set `fillIndex`. A lookup in the next cycle sees them.
- R6: Reset clears every valid bit, and `reqReady` is high after reset. A lookup after reset misses for any tag.
- R7: In a response cycle, `respPaddr` equals `{xlatPpn, page offset of the staged request}`.
- R8: A response in the same cycle as a fill of its own set reports the contents from before the fill.
- R9: In a response cycle, `reqReady` is high, so a new request can be accepted in the same cycle and answered next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Read request present |
| reqVaddr | input | 16 | Virtual address of the request |
| reqReady | output | 1 | Request is accepted on this edge when reqValid is high |
| xlatReq | output | 1 | Start of a translation lookup |
| xlatVpn | output | 8 | Virtual page number to translate |
| xlatValid | input | 1 | Translation result valid for the staged request |
| xlatPpn | input | 6 | Translated physical page number |
| fillValid | input | 1 | Write a line this cycle |
| fillIndex | input | 4 | Set written by the fill |
| fillPpn | input | 6 | Physical tag stored by the fill |
| fillLine | input | 64 | All words of the line, word 0 in the low bits |
| respHit | output | 1 | Response is a hit |
| respMiss | output | 1 | Response is a miss |
| respData | output | 16 | Selected word on a hit, zero otherwise |
| respPaddr | output | 14 | Physical address of the staged request in a response cycle |

## Verification
The assertions check four things on every cycle: hit and miss never rise together, a response never appears without a valid translation, a stalled stage keeps its offset, and each fill or reset leaves the valid bits in the expected state. The directed scenarios cover the rest. They check that the right word comes back from the right set, that a wrong physical tag misses, that a response racing a fill to its own set returns the old line, that a delayed translation completes the original request, and that the stage accepts a new request in the cycle it answers.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef struct packed {
    logic loadStage;
    logic stall;
    logic respond;
    logic fillWe;
  } vipt_strobe_t;

endpackage

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         xlatValid,
  input  logic         fillValid,
  output logic         reqReady,
  output logic         xlatReq,
  output vipt_strobe_t strobes
);

  logic stageFull;

  always_comb begin
    strobes.respond   = stageFull && xlatValid;
    strobes.stall     = stageFull && !xlatValid;
    reqReady          = !stageFull || xlatValid;
    strobes.loadStage = reqValid && reqReady;
    strobes.fillWe    = fillValid;
    xlatReq           = strobes.loadStage;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageFull <= 1'b0;
    end else if (strobes.loadStage) begin
      stageFull <= 1'b1;
    end else if (strobes.respond) begin
      stageFull <= 1'b0;
    end
  end

  // A stage without a translation result stays occupied.
  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (stageFull && !xlatValid) |=> stageFull);

  // While a response completes, the block always accepts a new request.
  assert_ready_on_respond_R9: assert property (@(posedge clk) disable iff (rst)
    (stageFull && xlatValid) |-> reqReady);

endmodule

// File: rtl/vipt_datapath.sv
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int PAGE_OFF_W = 8,
  parameter int PPN_W      = 6,
  parameter int IDX_W      = 4,
  parameter int WOFF_W     = 2,
  parameter int DATA_W     = 16,
  localparam int SETS      = 1 << IDX_W,
  localparam int WORDS     = 1 << WOFF_W,
  localparam int LINE_W    = WORDS * DATA_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  vipt_strobe_t                strobes,
  input  logic [PAGE_OFF_W-1:0]       reqOffset,
  input  logic [PPN_W-1:0]            xlatPpn,
  input  logic                        xlatValid,
  input  logic [IDX_W-1:0]            fillIndex,
  input  logic [PPN_W-1:0]            fillPpn,
  input  logic [LINE_W-1:0]           fillLine,
  output logic                        respHit,
  output logic                        respMiss,
  output logic [DATA_W-1:0]           respData,
  output logic [PPN_W+PAGE_OFF_W-1:0] respPaddr
);

  logic [PAGE_OFF_W-1:0] stageOff;
  logic [SETS-1:0]       validBits;
  logic [PPN_W-1:0]      tagMem  [SETS];
  logic [DATA_W-1:0]     dataMem [SETS][WORDS];
  logic [DATA_W-1:0]     fillWords [WORDS];

  logic [IDX_W-1:0]  setSel;
  logic [WOFF_W-1:0] wordSel;
  logic              rdValid;
  logic [PPN_W-1:0]  rdTag;
  logic [DATA_W-1:0] rdWord;
  logic              tagMatch;

  // Offset register: holds the untranslated bits while translation runs.
  always_ff @(posedge clk) begin
    if (rst) begin
      stageOff <= '0;
    end else if (strobes.loadStage) begin
      stageOff <= reqOffset;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : gFillSplit
    assign fillWords[w] = fillLine[w*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validBits <= '0;
    end else if (strobes.fillWe) begin
      validBits[fillIndex] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fillWe) begin
      tagMem[fillIndex] <= fillPpn;
      for (int w = 0; w < WORDS; w++) begin
        dataMem[fillIndex][w] <= fillWords[w];
      end
    end
  end

  // Array read uses only page-offset bits, in parallel with translation.
  always_comb begin
    setSel   = stageOff[WOFF_W +: IDX_W];
    wordSel  = stageOff[WOFF_W-1:0];
    rdValid  = validBits[setSel];
    rdTag    = tagMem[setSel];
    rdWord   = dataMem[setSel][wordSel];
    tagMatch = rdValid && (rdTag == xlatPpn);
    respHit  = strobes.respond && tagMatch;
    respMiss = strobes.respond && !tagMatch;
    respData = respHit ? rdWord : '0;
    respPaddr = {xlatPpn, stageOff};
  end

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({respHit, respMiss}));

  assert_no_resp_without_xlat_R4: assert property (@(posedge clk) disable iff (rst)
    (respHit || respMiss) |-> xlatValid);

  assert_offset_held_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.stall |=> $stable(stageOff));

  assert_fill_sets_valid_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.fillWe |=> validBits[$past(fillIndex)]);

  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> (validBits == '0));

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int VPN_W      = 8,
  parameter int PAGE_OFF_W = 8,
  parameter int PPN_W      = 6,
  parameter int IDX_W      = 4,
  parameter int WOFF_W     = 2,
  parameter int DATA_W     = 16,
  localparam int VADDR_W   = VPN_W + PAGE_OFF_W,
  localparam int PADDR_W   = PPN_W + PAGE_OFF_W,
  localparam int LINE_W    = (1 << WOFF_W) * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [VADDR_W-1:0] reqVaddr,
  output logic               reqReady,
  output logic               xlatReq,
  output logic [VPN_W-1:0]   xlatVpn,
  input  logic               xlatValid,
  input  logic [PPN_W-1:0]   xlatPpn,
  input  logic               fillValid,
  input  logic [IDX_W-1:0]   fillIndex,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [LINE_W-1:0]  fillLine,
  output logic               respHit,
  output logic               respMiss,
  output logic [DATA_W-1:0]  respData,
  output logic [PADDR_W-1:0] respPaddr
);

  if (IDX_W + WOFF_W > PAGE_OFF_W) begin : gBadSplit
    $error("set index and word offset must fit inside the page offset");
  end
  if (WOFF_W < 1) begin : gBadWords
    $error("word offset width must be at least one");
  end

  vipt_strobe_t strobes;

  assign xlatVpn = reqVaddr[VADDR_W-1 -: VPN_W];

  vipt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .xlatValid (xlatValid),
    .fillValid (fillValid),
    .reqReady  (reqReady),
    .xlatReq   (xlatReq),
    .strobes   (strobes)
  );

  vipt_datapath #(
    .PAGE_OFF_W (PAGE_OFF_W),
    .PPN_W      (PPN_W),
    .IDX_W      (IDX_W),
    .WOFF_W     (WOFF_W),
    .DATA_W     (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .reqOffset (reqVaddr[PAGE_OFF_W-1:0]),
    .xlatPpn   (xlatPpn),
    .xlatValid (xlatValid),
    .fillIndex (fillIndex),
    .fillPpn   (fillPpn),
    .fillLine  (fillLine),
    .respHit   (respHit),
    .respMiss  (respMiss),
    .respData  (respData),
    .respPaddr (respPaddr)
  );

endmodule

// File: tb/vipt_dcache_tb.sv
module vipt_dcache_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [15:0] reqVaddr;
  logic        reqReady;
  logic        xlatReq;
  logic [7:0]  xlatVpn;
  logic        xlatValid;
  logic [5:0]  xlatPpn;
  logic        fillValid;
  logic [3:0]  fillIndex;
  logic [5:0]  fillPpn;
  logic [63:0] fillLine;
  logic        respHit;
  logic        respMiss;
  logic [15:0] respData;
  logic [13:0] respPaddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vipt_dcache u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqReady(reqReady), .xlatReq(xlatReq), .xlatVpn(xlatVpn),
    .xlatValid(xlatValid), .xlatPpn(xlatPpn), .fillValid(fillValid),
    .fillIndex(fillIndex), .fillPpn(fillPpn), .fillLine(fillLine),
    .respHit(respHit), .respMiss(respMiss), .respData(respData),
    .respPaddr(respPaddr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkWord(int set, int w, logic [7:0] salt);
    return {salt, set[3:0], 2'b00, w[1:0]};
  endfunction

  function automatic logic [63:0] mkLine(int set, logic [7:0] salt);
    logic [63:0] l;
    for (int w = 0; w < 4; w++) l[w*16 +: 16] = mkWord(set, w, salt);
    return l;
  endfunction

  task automatic doFill(int set, logic [5:0] ppn, logic [7:0] salt);
    @(negedge clk);
    fillValid = 1'b1; fillIndex = set[3:0]; fillPpn = ppn;
    fillLine  = mkLine(set, salt);
    @(posedge clk);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  // Full lookup: accept, optional translation delay, then response.
  task automatic lookup(string tag, logic [15:0] va, logic [5:0] ppn, int delay,
                        logic expHit, logic [15:0] expData);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va;
    #1;
    check({tag, " R1 ready"}, reqReady, 1);
    check({tag, " R1 xlatReq"}, xlatReq, 1);
    check({tag, " R1 vpn"}, xlatVpn, va[15:8]);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqVaddr = 16'hFFFF;
    for (int d = 0; d < delay; d++) begin
      #1;
      check({tag, " R4 no flags"}, {respHit, respMiss}, 0);
      check({tag, " R4 not ready"}, reqReady, 0);
      @(posedge clk);
      @(negedge clk);
    end
    xlatValid = 1'b1; xlatPpn = ppn;
    #1;
    check({tag, expHit ? " R2 hit" : " R3 miss"}, {respHit, respMiss}, {expHit, !expHit});
    check({tag, expHit ? " R2 data" : " R3 data zero"}, respData, expData);
    check({tag, " R7 paddr"}, respPaddr, {ppn, va[7:0]});
    @(posedge clk);
    @(negedge clk);
    xlatValid = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check("R6 ready after reset", reqReady, 1);
    check("R6 no flags", {respHit, respMiss}, 0);
    lookup("R6 cold", 16'h1234, 6'h0D, 0, 1'b0, 16'h0);
    lookup("R6 cold2", 16'hAB00, 6'h00, 0, 1'b0, 16'h0);
  endtask

  task automatic testHitMiss();
    doFill(5, 6'h2A, 8'h11);
    lookup("R5 fill visible", {8'h77, 8'h16}, 6'h2A, 0, 1'b1, mkWord(5, 2, 8'h11));
    lookup("R1 upper offset bits", {8'h03, 8'hD7}, 6'h2A, 0, 1'b1, mkWord(5, 3, 8'h11));
    lookup("R3 wrong ppn", {8'h77, 8'h14}, 6'h2B, 0, 1'b0, 16'h0);
    lookup("R3 invalid set", {8'h77, 8'h18}, 6'h2A, 0, 1'b0, 16'h0);
  endtask

  task automatic testDelay();
    lookup("R4 delayed", {8'h40, 8'h15}, 6'h2A, 3, 1'b1, mkWord(5, 1, 8'h11));
  endtask

  task automatic testSweep();
    for (int s = 0; s < 16; s++) doFill(s, 6'(s + 8), 8'h5A);
    for (int s = 0; s < 16; s += 5) begin
      lookup("R5 sweep", {8'(s * 3), 2'b00, 4'(s), 2'(s)}, 6'(s + 8), 0,
             1'b1, mkWord(s, s % 4, 8'h5A));
    end
  endtask

  task automatic testFillRace();
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {8'h22, 8'h0C};
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    xlatValid = 1'b1; xlatPpn = 6'h0B;
    fillValid = 1'b1; fillIndex = 4'd3; fillPpn = 6'h0B; fillLine = mkLine(3, 8'hC3);
    #1;
    check("R8 race hit", {respHit, respMiss}, 2'b10);
    check("R8 race old data", respData, mkWord(3, 0, 8'h5A));
    @(posedge clk);
    @(negedge clk);
    xlatValid = 1'b0; fillValid = 1'b0;
    lookup("R8 after race", {8'h22, 8'h0C}, 6'h0B, 0, 1'b1, mkWord(3, 0, 8'hC3));
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {8'h90, 8'h29};
    @(posedge clk);
    @(negedge clk);
    reqVaddr = {8'h91, 8'h3E};
    xlatValid = 1'b1; xlatPpn = 6'h12;
    #1;
    check("R9 ready while responding", reqReady, 1);
    check("R9 first hit", {respHit, respMiss}, 2'b10);
    check("R9 first data", respData, mkWord(10, 1, 8'h5A));
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; xlatPpn = 6'h17;
    #1;
    check("R9 second hit", {respHit, respMiss}, 2'b10);
    check("R9 second data", respData, mkWord(15, 2, 8'h5A));
    check("R9 R7 second paddr", respPaddr, {6'h17, 8'h3E});
    @(posedge clk);
    @(negedge clk);
    xlatValid = 1'b0;
    #1;
    check("R9 stage empty", reqReady, 1);
  endtask

  initial begin
    rst = 1'b1; reqValid = 1'b0; reqVaddr = '0; xlatValid = 1'b0; xlatPpn = '0;
    fillValid = 1'b0; fillIndex = '0; fillPpn = '0; fillLine = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testHitMiss();
    testDelay();
    testSweep();
    testFillRace();
    testBackToBack();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule